// File: doc/BRIEF.md
# Cascaded Lookup Bus Ownership Controller

This block is the per-device arbitration logic for a chain of up to eight lookup devices. The devices are connected in depth and share one external SRAM address and control bus. Every device in the chain sees the same command in the same cycle. Each device then decides for itself whether it drives the shared bus and the result strobe.

On a search, the first device in the chain with a local match becomes the owner. That device raises a cascade flag that travels downstream within the same cycle and silences every device below it. If no device matches, ownership falls to the device configured as last in the chain. On a direct read or write, the device whose ID equals the target ID becomes the owner. When the target is the reserved global ID, the last device becomes the owner.

The owner forms the SRAM address from bus-supplied high bits and a low index. The low index is the match index on a search hit, the command address on a read or write, and zero on a search miss. All bus outputs then pass through a configurable pipeline delay. The block also keeps a per-entry valid bitmap that yields a device-full flag, and it ANDs a full flag along the chain to report a table-full condition.

Top module: `casc_bus_ctl`

## Requirements
- R1: On a search (op_i = 2'b01), a device with hit_i high and casc_hit_i low owns the bus with res_hit_o high, and casc_hit_o is high in the same cycle.
- R2: casc_hit_i high forces casc_hit_o high in the same cycle and keeps the device from owning on a search.
- R3: On a search where no device in the chain has a hit, only the device with last_dev_i high owns, with res_hit_o low, sram_we_o low, and the address low field zero.
- R4: On a read (op_i = 2'b10) or write (op_i = 2'b11), the device whose dev_id_i equals tgt_id_i owns and drives sram_cs_o high and address {bus_bits_i, cmd_addr_i}; sram_we_o is high only for a write.
- R5: A read or write whose tgt_id_i is all ones (global ID) is owned only by the device with last_dev_i high.
- R6: On a search hit, the owner's address is {bus_bits_i, hit_idx_i}, with bus bits in the upper field.
- R7: Bus outputs appear exactly LAT clock edges after the command is sampled; an idle command (op_i = 2'b00) yields no owner; a non-owner drives zero on all bus outputs.
- R8: Across a chain, at most one device has drv_oe_o high in any cycle.
- R9: dev_full_o is high exactly when all DEPTH entries are valid; ent_set_i marks ent_idx_i valid and ent_clr_i clears it, and set wins when both are high. The change shows one edge after the request.
- R10: full_chain_o equals full_chain_i AND dev_full_o; tbl_full_o equals full_chain_o on the last device and is low on every other device.
- R11: After reset, drv_oe_o is low and all entries are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_id_i | input | ID_W | Position ID of this device |
| last_dev_i | input | 1 | High on the last device of the chain |
| op_i | input | 2 | 00 idle, 01 search, 10 read, 11 write |
| tgt_id_i | input | ID_W | Target ID of a read/write; all ones is global |
| bus_bits_i | input | HI_W | High address bits supplied on the command bus |
| cmd_addr_i | input | IDX_W | Low address of a read/write |
| hit_i | input | 1 | Local match result |
| hit_idx_i | input | IDX_W | Lowest local match index |
| casc_hit_i | input | 1 | A device upstream has a match |
| casc_hit_o | output | 1 | This device or one upstream has a match |
| ent_set_i | input | 1 | Mark entry valid |
| ent_clr_i | input | 1 | Mark entry invalid |
| ent_idx_i | input | IDX_W | Entry index for set/clear |
| full_chain_i | input | 1 | All upstream devices full (tie high on first) |
| full_chain_o | output | 1 | This device and all upstream full |
| dev_full_o | output | 1 | All local entries valid |
| tbl_full_o | output | 1 | Whole table full (last device only) |
| drv_oe_o | output | 1 | Enable for this device's shared-bus drivers |
| sram_cs_o | output | 1 | SRAM select |
| sram_we_o | output | 1 | SRAM write enable |
| res_hit_o | output | 1 | Result strobe: owner holds a match |
| sram_addr_o | output | ADDR_W | SRAM address |

## Verification
A wrong ownership decision shows up at the ports exactly LAT edges after the command. It appears either as two devices enabling their drivers at once, or as no owner where the last device should have taken the bus. A cascade flag that fails to propagate shows up in the same cycle on casc_hit_o of the next device. A corrupted valid bitmap shows on dev_full_o one edge after the set or clear. The bench reaches that corruption by filling every device and then clearing single entries, and the fault reaches tbl_full_o at the end of the chain in the same cycle.

// File: rtl/casc_pkg.sv
package casc_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_SRCH = 2'b01,
    OP_RD   = 2'b10,
    OP_WR   = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SEL_MISS = 2'b00,
    SEL_HIT  = 2'b01,
    SEL_CMD  = 2'b10
  } addr_sel_e;
endpackage

// File: rtl/casc_own_decide.sv
module casc_own_decide
  import casc_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic [1:0]      op_i,
  input  logic [ID_W-1:0] dev_id_i,
  input  logic [ID_W-1:0] tgt_id_i,
  input  logic            last_dev_i,
  input  logic            hit_i,
  input  logic            casc_hit_i,
  output logic            casc_hit_o,
  output logic            own_o,
  output logic            cs_o,
  output logic            we_o,
  output logic            res_hit_o,
  output addr_sel_e       sel_o
);
  localparam logic [ID_W-1:0] GLOBAL_ID = '1;

  logic is_srch, is_cmd, lhit, win, miss_own, cmd_own;

  always_comb begin
    is_srch  = (op_i == OP_SRCH);
    is_cmd   = (op_i == OP_RD) || (op_i == OP_WR);
    lhit     = is_srch & hit_i;
    win      = lhit & ~casc_hit_i;
    // last device takes a chain-wide miss
    miss_own = is_srch & last_dev_i & ~casc_hit_i & ~hit_i;
    cmd_own  = is_cmd & ((tgt_id_i == dev_id_i) |
                         ((tgt_id_i == GLOBAL_ID) & last_dev_i));
    casc_hit_o = casc_hit_i | lhit;
    own_o      = win | miss_own | cmd_own;
    cs_o       = own_o;
    we_o       = cmd_own & (op_i == OP_WR);
    res_hit_o  = win;
    if (is_cmd)   sel_o = SEL_CMD;
    else if (win) sel_o = SEL_HIT;
    else          sel_o = SEL_MISS;
  end
endmodule

// File: rtl/casc_addr_form.sv
module casc_addr_form
  import casc_pkg::*;
#(
  parameter int HI_W  = 4,
  parameter int IDX_W = 4,
  localparam int ADDR_W = HI_W + IDX_W
) (
  input  addr_sel_e        sel_i,
  input  logic             own_i,
  input  logic [HI_W-1:0]  bus_bits_i,
  input  logic [IDX_W-1:0] hit_idx_i,
  input  logic [IDX_W-1:0] cmd_addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [IDX_W-1:0] low;

  always_comb begin
    unique case (sel_i)
      SEL_HIT: low = hit_idx_i;
      SEL_CMD: low = cmd_addr_i;
      default: low = '0;
    endcase
    addr_o = own_i ? {bus_bits_i, low} : '0;
  end
endmodule

// File: rtl/casc_delay.sv
module casc_delay #(
  parameter int W   = 8,
  parameter int LAT = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= '0;
    else         stg[0] <= d_i;
  end

  for (genvar i = 1; i < LAT; i++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[i] <= '0;
      else         stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[LAT-1];
endmodule

// File: rtl/casc_occ.sv
module casc_occ #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             full_o
);
  logic [DEPTH-1:0] vld_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        vld_q[i] <= 1'b0;
      else if (idx_i == IDX_W'(i)) begin
        if (set_i)      vld_q[i] <= 1'b1;
        else if (clr_i) vld_q[i] <= 1'b0;
      end
    end
  end

  assign full_o = &vld_q;
endmodule

// File: rtl/casc_bus_ctl.sv
module casc_bus_ctl
  import casc_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int HI_W    = 4,
  parameter int LAT     = 2,
  parameter int MAX_DEV = 8,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ID_W   = $clog2(MAX_DEV) + 1,
  localparam int ADDR_W = HI_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ID_W-1:0]   dev_id_i,
  input  logic              last_dev_i,
  input  logic [1:0]        op_i,
  input  logic [ID_W-1:0]   tgt_id_i,
  input  logic [HI_W-1:0]   bus_bits_i,
  input  logic [IDX_W-1:0]  cmd_addr_i,
  input  logic              hit_i,
  input  logic [IDX_W-1:0]  hit_idx_i,
  input  logic              casc_hit_i,
  output logic              casc_hit_o,
  input  logic              ent_set_i,
  input  logic              ent_clr_i,
  input  logic [IDX_W-1:0]  ent_idx_i,
  input  logic              full_chain_i,
  output logic              full_chain_o,
  output logic              dev_full_o,
  output logic              tbl_full_o,
  output logic              drv_oe_o,
  output logic              sram_cs_o,
  output logic              sram_we_o,
  output logic              res_hit_o,
  output logic [ADDR_W-1:0] sram_addr_o
);
  localparam int PW = ADDR_W + 4;

  logic              own, cs, we, rh;
  addr_sel_e         sel;
  logic [ADDR_W-1:0] addr;
  logic [PW-1:0]     pay_d, pay_q;

  casc_own_decide #(.ID_W(ID_W)) u_dec (
    .op_i      (op_i),
    .dev_id_i  (dev_id_i),
    .tgt_id_i  (tgt_id_i),
    .last_dev_i(last_dev_i),
    .hit_i     (hit_i),
    .casc_hit_i(casc_hit_i),
    .casc_hit_o(casc_hit_o),
    .own_o     (own),
    .cs_o      (cs),
    .we_o      (we),
    .res_hit_o (rh),
    .sel_o     (sel)
  );

  casc_addr_form #(.HI_W(HI_W), .IDX_W(IDX_W)) u_addr (
    .sel_i     (sel),
    .own_i     (own),
    .bus_bits_i(bus_bits_i),
    .hit_idx_i (hit_idx_i),
    .cmd_addr_i(cmd_addr_i),
    .addr_o    (addr)
  );

  assign pay_d = {own, cs, we, rh, addr};

  casc_delay #(.W(PW), .LAT(LAT)) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pay_d),
    .q_o   (pay_q)
  );

  assign {drv_oe_o, sram_cs_o, sram_we_o, res_hit_o, sram_addr_o} = pay_q;

  casc_occ #(.DEPTH(DEPTH)) u_occ (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (ent_set_i),
    .clr_i (ent_clr_i),
    .idx_i (ent_idx_i),
    .full_o(dev_full_o)
  );

  assign full_chain_o = full_chain_i & dev_full_o;
  assign tbl_full_o   = full_chain_o & last_dev_i;
endmodule

// File: rtl/casc_bus_ctl_chk.sv
module casc_bus_ctl_chk #(
  parameter int LAT = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       last_dev_i,
  input logic [1:0] op_i,
  input logic       hit_i,
  input logic       casc_hit_i,
  input logic       casc_hit_o,
  input logic       ent_set_i,
  input logic       ent_clr_i,
  input logic       full_chain_i,
  input logic       full_chain_o,
  input logic       dev_full_o,
  input logic       tbl_full_o,
  input logic       drv_oe_o,
  input logic       sram_cs_o,
  input logic       sram_we_o,
  input logic       res_hit_o
);
  localparam int CW = $clog2(LAT + 1) + 1;
  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              idle_cnt <= '0;
    else if (op_i != 2'b00)   idle_cnt <= '0;
    else if (idle_cnt < CW'(LAT)) idle_cnt <= idle_cnt + 1'b1;
  end

  // R1
  hit_casc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b01 && hit_i) |-> casc_hit_o);
  // R2
  pass_casc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casc_hit_i |-> casc_hit_o);
  // R7
  gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_cs_o || sram_we_o || res_hit_o) |-> drv_oe_o);
  // R7
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_cnt >= CW'(LAT)) |-> !drv_oe_o);
  // R9
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ent_set_i && !ent_clr_i) |=> $stable(dev_full_o));
  // R10
  chain_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_chain_o |-> (full_chain_i && dev_full_o));
  // R10
  tbl_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_full_o |-> last_dev_i);
endmodule

bind casc_bus_ctl casc_bus_ctl_chk #(.LAT(LAT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .last_dev_i  (last_dev_i),
  .op_i        (op_i),
  .hit_i       (hit_i),
  .casc_hit_i  (casc_hit_i),
  .casc_hit_o  (casc_hit_o),
  .ent_set_i   (ent_set_i),
  .ent_clr_i   (ent_clr_i),
  .full_chain_i(full_chain_i),
  .full_chain_o(full_chain_o),
  .dev_full_o  (dev_full_o),
  .tbl_full_o  (tbl_full_o),
  .drv_oe_o    (drv_oe_o),
  .sram_cs_o   (sram_cs_o),
  .sram_we_o   (sram_we_o),
  .res_hit_o   (res_hit_o)
);

// File: tb/casc_bus_ctl_test.sv
module casc_bus_ctl_test;
  localparam int NDEV = 4, DEPTH = 16, HI_W = 4, LAT = 2, MAX_DEV = 8;
  localparam int IDX_W = $clog2(DEPTH), ID_W = $clog2(MAX_DEV) + 1;
  localparam int ADDR_W = HI_W + IDX_W;
  localparam logic [ID_W-1:0] GID = '1;

  typedef struct packed {
    logic oe; logic cs; logic we; logic rh; logic [ADDR_W-1:0] addr;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]       op;
  logic [ID_W-1:0]  tgt;
  logic [HI_W-1:0]  bus;
  logic [IDX_W-1:0] cmd;
  logic             hit  [NDEV];
  logic [IDX_W-1:0] hidx [NDEV];
  logic             eset [NDEV];
  logic             eclr [NDEV];
  logic [IDX_W-1:0] eidx [NDEV];
  logic             casc [NDEV+1];
  logic             fch  [NDEV+1];
  logic dfull [NDEV], tfull [NDEV], oe [NDEV], cs [NDEV], we [NDEV], rh [NDEV];
  logic [ADDR_W-1:0] addr [NDEV];

  assign casc[0] = 1'b0;
  assign fch[0]  = 1'b1;

  for (genvar g = 0; g < NDEV; g++) begin : g_dev
    casc_bus_ctl #(.DEPTH(DEPTH), .HI_W(HI_W), .LAT(LAT), .MAX_DEV(MAX_DEV)) uut (
      .clk_i(clk), .rst_ni(rst_ni), .dev_id_i(ID_W'(g)), .last_dev_i(g == NDEV-1),
      .op_i(op), .tgt_id_i(tgt), .bus_bits_i(bus), .cmd_addr_i(cmd),
      .hit_i(hit[g]), .hit_idx_i(hidx[g]), .casc_hit_i(casc[g]), .casc_hit_o(casc[g+1]),
      .ent_set_i(eset[g]), .ent_clr_i(eclr[g]), .ent_idx_i(eidx[g]),
      .full_chain_i(fch[g]), .full_chain_o(fch[g+1]), .dev_full_o(dfull[g]),
      .tbl_full_o(tfull[g]), .drv_oe_o(oe[g]), .sram_cs_o(cs[g]), .sram_we_o(we[g]),
      .res_hit_o(rh[g]), .sram_addr_o(addr[g])
    );
  end

  exp_t             exq [LAT][NDEV];
  string            tgq [LAT];
  logic [DEPTH-1:0] mv  [NDEV];
  int total = 0, bad = 0;

  function automatic exp_t calc(int d);
    exp_t e = '0;
    int first = -1;
    for (int i = NDEV-1; i >= 0; i--) if (hit[i]) first = i;
    if (op == 2'b01) begin
      if (first == d) begin
        e.oe = 1; e.cs = 1; e.rh = 1; e.addr = {bus, hidx[d]};
      end else if (first < 0 && d == NDEV-1) begin
        e.oe = 1; e.cs = 1; e.addr = {bus, IDX_W'(0)};
      end
    end else if (op[1]) begin
      if (tgt == ID_W'(d) || (tgt == GID && d == NDEV-1)) begin
        e.oe = 1; e.cs = 1; e.we = op[0]; e.addr = {bus, cmd};
      end
    end
    return e;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=0x%0h exp=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    int n = 0;
    logic all_f = 1'b1;
    for (int d = 0; d < NDEV; d++) begin
      exp_t a;
      a = '{oe: oe[d], cs: cs[d], we: we[d], rh: rh[d], addr: addr[d]};
      chk(tgq[LAT-1], $sformatf("dev%0d bus", d), 32'(a), 32'(exq[LAT-1][d]));
      if (oe[d]) n++;
      chk("R9", $sformatf("dev%0d full", d), 32'(dfull[d]), 32'(&mv[d]));
      all_f = all_f & (&mv[d]);
      chk("R10", $sformatf("dev%0d chain", d), 32'(fch[d+1]), 32'(all_f));
    end
    chk("R8", "driver count", 32'(n > 1), 32'd0);
    for (int d = 0; d < NDEV; d++)
      chk("R10", $sformatf("dev%0d table", d), 32'(tfull[d]),
          32'((d == NDEV-1) && all_f));
  endtask

  task automatic apply(logic [1:0] k, logic [ID_W-1:0] t, logic [NDEV-1:0] hm,
                       logic [NDEV-1:0] sm, logic [NDEV-1:0] cm,
                       logic [IDX_W-1:0] fi, bit rnd_idx);
    logic any;
    @(negedge clk);
    check_all();
    op = k; tgt = t; bus = HI_W'($urandom); cmd = IDX_W'($urandom);
    for (int d = 0; d < NDEV; d++) begin
      hit[d] = hm[d]; hidx[d] = IDX_W'($urandom);
      eset[d] = sm[d]; eclr[d] = cm[d];
      eidx[d] = rnd_idx ? IDX_W'($urandom) : fi;
    end
    #1;
    any = 1'b0;
    for (int d = 0; d < NDEV; d++) begin
      any = any | (hm[d] && k == 2'b01);
      chk("R1 R2", $sformatf("dev%0d cascade", d), 32'(casc[d+1]), 32'(any));
    end
    for (int i = LAT-1; i > 0; i--) begin
      tgq[i] = tgq[i-1];
      for (int d = 0; d < NDEV; d++) exq[i][d] = exq[i-1][d];
    end
    for (int d = 0; d < NDEV; d++) exq[0][d] = calc(d);
    if (k == 2'b01) tgq[0] = (hm != 0) ? "R1 R6" : "R3";
    else if (k[1]) tgq[0] = (t == GID) ? "R5" : "R4";
    else tgq[0] = "R7";
    for (int d = 0; d < NDEV; d++)
      if (eset[d]) mv[d][eidx[d]] = 1'b1;
      else if (eclr[d]) mv[d][eidx[d]] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    op = 2'b00; tgt = '0; bus = '0; cmd = '0;
    for (int d = 0; d < NDEV; d++) begin
      hit[d] = 0; hidx[d] = '0; eset[d] = 0; eclr[d] = 0; eidx[d] = '0; mv[d] = '0;
    end
    for (int i = 0; i < LAT; i++) begin
      tgq[i] = "R11";
      for (int d = 0; d < NDEV; d++) exq[i][d] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int d = 0; d < NDEV; d++) begin
      chk("R11", "reset oe", 32'(oe[d]), 32'd0);
      chk("R11", "reset full", 32'(dfull[d]), 32'd0);
    end
    rst_ni = 1'b1;
    // directed searches
    apply(2'b01, '0, 4'b1111, '0, '0, '0, 0);
    apply(2'b01, '0, 4'b1000, '0, '0, '0, 0);
    apply(2'b01, '0, 4'b0000, '0, '0, '0, 0);
    apply(2'b01, '0, 4'b0100, '0, '0, '0, 0);
    apply(2'b01, '0, 4'b0110, '0, '0, '0, 0);
    // directed read/write
    apply(2'b10, 4'd1, 4'b1111, '0, '0, '0, 0);
    apply(2'b11, 4'd3, '0, '0, '0, '0, 0);
    apply(2'b10, GID, '0, '0, '0, '0, 0);
    apply(2'b11, GID, '0, '0, '0, '0, 0);
    apply(2'b10, 4'd9, '0, '0, '0, '0, 0);
    apply(2'b00, 4'd0, 4'b1111, '0, '0, '0, 0);
    // fill every device
    for (int i = 0; i < DEPTH; i++)
      apply(2'b00, '0, '0, 4'b1111, '0, IDX_W'(i), 0);
    apply(2'b00, '0, '0, '0, '0, '0, 0);
    apply(2'b00, '0, '0, '0, 4'b0010, IDX_W'(5), 0);
    apply(2'b00, '0, '0, 4'b0010, 4'b0010, IDX_W'(5), 0);
    apply(2'b00, '0, '0, '0, 4'b1000, IDX_W'(0), 0);
    apply(2'b00, '0, '0, 4'b1000, '0, IDX_W'(0), 0);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [NDEV-1:0] hm, sm, cm;
      logic [ID_W-1:0] t;
      for (int d = 0; d < NDEV; d++) begin
        hm[d] = ($urandom % 10) < 3;
        sm[d] = ($urandom % 10) < 2;
        cm[d] = ($urandom % 10) < 2;
      end
      t = (($urandom % 4) == 0) ? GID : ID_W'($urandom % 6);
      apply(2'($urandom), t, hm, sm, cm, '0, 1);
    end
    for (int i = 0; i <= LAT; i++) apply(2'b00, '0, '0, '0, '0, '0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule